// File: doc/BRIEF.md
# Programmable Bit-Time Serial Transceiver

This block moves bytes over a single-wire serial bus using a bit length that software programs as a count of module clock cycles. It measures no baud rate and never resynchronizes. A transmitted bit lasts exactly the programmed count. A received frame is sampled on a fixed grid: the grid starts at the filtered falling edge of the start bit and uses only the programmed count to place each later sample.

A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The transmitter accepts a byte on a start strobe when it is idle. The receiver arms on a falling edge when receive is enabled, checks the start bit at mid-bit, and then collects the byte. Each direction reports completion with a one-cycle done pulse and shows its activity on a busy flag. The programmed count must stay at or above 16, because the upstream input filter cannot react faster than that. The count must be held stable while a frame is in flight.

Top module: `bittime_xcvr`

## Requirements
- R1: After reset the transmit line is high, both busy flags and both done pulses are low, the received byte is 0x00 and the framing-error flag is 0.
- R2: A transmitted frame is: the start bit at 0, then the data bits from bit 0 up to bit 7, then the stop bit at 1. The line is high whenever the transmitter is idle.
- R3: Every transmitted bit, start and stop included, lasts exactly `bitTime` clock cycles. The start bit begins in the cycle after the clock edge that accepts `txStart`, so the whole frame lasts 10×`bitTime` cycles.
- R4: A `txStart` pulse that arrives while `txBusy` is high is ignored. The frame in progress continues unchanged.
- R5: `txDone` goes high for exactly one cycle when the stop bit completes. `txBusy` drops in that same cycle.
- R6: The receiver registers a falling edge at the first clock edge at which `rxLine` is 0 after being 1. It takes the start-bit sample `bitTime>>1` clock edges later (an odd count rounds down). Each later sample comes `bitTime` clock edges after the previous one, so the stop bit is sampled 1+(`bitTime`>>1)+9×`bitTime` edges after the cycle in which the line was driven low.
- R7: If the start-bit sample reads 1, the receiver abandons the frame. It drops `rxBusy` and produces no `rxDone`.
- R8: Received data bits are assembled least significant bit first. `rxByte` takes the new value at the same edge that raises `rxDone`, and `rxDone` is a one-cycle pulse.
- R9: `rxFrameErr` is updated with each `rxDone`. It is 1 when the stop-bit sample is 0, and 0 otherwise.
- R10: While `rxEnable` is 0, falling edges on `rxLine` do not start a frame, and `rxBusy` stays 0.
- R11: `bitTime` must be at least 16 whenever the block is out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTime | input | BT_W (8) | Bit length in clock cycles, at least 16 |
| rxLine | input | 1 | Filtered receive line |
| rxEnable | input | 1 | Allows a falling edge to start reception |
| txByte | input | 8 | Byte to transmit |
| txStart | input | 1 | Transmit request, accepted only when idle |
| txLine | output | 1 | Transmit line, idles high |
| rxByte | output | 8 | Last received byte |
| rxFrameErr | output | 1 | Stop bit of the last received frame was low |
| rxDone | output | 1 | One-cycle pulse when a received frame completes |
| rxBusy | output | 1 | Receiver is inside a frame |
| txDone | output | 1 | One-cycle pulse when the stop bit has been sent |
| txBusy | output | 1 | Transmitter is sending a frame |

## Verification
The hardest cases to reach from the ports are a start-bit sample that lands on a line that has already gone high again, and a stop bit that is sampled low. Both require the receive waveform to be placed against the sample grid to the exact cycle. The bench builds each receive frame one cycle at a time from the programmed count. It creates a low glitch shorter than half a bit to force the abandon path, and it drives deliberately low stop bits. It also uses an odd bit count to check the rounding of the half-bit point, and it fires a second transmit strobe in the middle of a frame.

// File: rtl/bittime_xcvr_pkg.sv
package bittime_xcvr_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int BT_MIN     = 16;

  typedef struct packed {
    logic txLoad;     // accept a new byte into the frame register
    logic txShift;    // advance to the next transmit bit
    logic rxShift;    // capture a data sample
    logic rxCapture;  // stop sample: publish byte and frame status
  } ctrlStrobes_t;
endpackage

// File: rtl/bittime_xcvr_ctrl.sv
module bittime_xcvr_ctrl
  import bittime_xcvr_pkg::*;
#(
  parameter int BT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [BT_W-1:0] bitTime,
  input  logic            rxLine,
  input  logic            rxEnable,
  input  logic            txStart,
  output ctrlStrobes_t    strobes,
  output logic            txBusy,
  output logic            txDone,
  output logic            rxBusy,
  output logic            rxDone
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic [BT_W-1:0]  btLast, halfLast;
  logic [BT_W-1:0]  txCnt, rxCnt, rxTarget;
  logic [IDX_W-1:0] txIdx, rxIdx;
  logic             txActive, rxActive, rxPrev;
  logic             txBitEnd, rxHit, rxFall;

  assign btLast   = bitTime - BT_W'(1);
  assign halfLast = (bitTime >> 1) - BT_W'(1);

  // transmit sequencing
  assign txBitEnd = txActive && (txCnt == btLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive <= 1'b0;
      txCnt    <= '0;
      txIdx    <= '0;
      txDone   <= 1'b0;
    end else begin
      txDone <= 1'b0;
      if (!txActive) begin
        if (txStart) begin
          txActive <= 1'b1;
          txCnt    <= '0;
          txIdx    <= '0;
        end
      end else if (txBitEnd) begin
        txCnt <= '0;
        if (txIdx == LAST_IDX) begin
          txActive <= 1'b0;
          txDone   <= 1'b1;
        end else begin
          txIdx <= txIdx + 1'b1;
        end
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  // receive sequencing
  assign rxFall   = rxPrev && !rxLine;
  assign rxTarget = (rxIdx == '0) ? halfLast : btLast;
  assign rxHit    = rxActive && (rxCnt == rxTarget);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev   <= 1'b1;
      rxActive <= 1'b0;
      rxCnt    <= '0;
      rxIdx    <= '0;
      rxDone   <= 1'b0;
    end else begin
      rxPrev <= rxLine;
      rxDone <= 1'b0;
      if (!rxActive) begin
        if (rxEnable && rxFall) begin
          rxActive <= 1'b1;
          rxCnt    <= '0;
          rxIdx    <= '0;
        end
      end else if (rxHit) begin
        rxCnt <= '0;
        if (rxIdx == '0 && rxLine) begin
          rxActive <= 1'b0;
        end else if (rxIdx == LAST_IDX) begin
          rxActive <= 1'b0;
          rxDone   <= 1'b1;
        end else begin
          rxIdx <= rxIdx + 1'b1;
        end
      end else begin
        rxCnt <= rxCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.txLoad    = txStart && !txActive;
    strobes.txShift   = txBitEnd && (txIdx != LAST_IDX);
    strobes.rxShift   = rxHit && (rxIdx != '0) && (rxIdx != LAST_IDX);
    strobes.rxCapture = rxHit && (rxIdx == LAST_IDX);
  end

  assign txBusy = txActive;
  assign rxBusy = rxActive;

  AST_TXDONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone); // R5
  AST_RX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rxBusy |-> (rxCnt < bitTime)); // R6
  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!rxBusy && !rxEnable) |=> !rxBusy); // R10
  AST_RXDONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> !rxBusy); // R8
endmodule

// File: rtl/bittime_xcvr_dp.sv
module bittime_xcvr_dp
  import bittime_xcvr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [DATA_BITS-1:0] txByte,
  input  logic                 rxLine,
  output logic                 txLine,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxFrameErr
);
  logic [FRAME_BITS-1:0] txFrame;
  logic [DATA_BITS-1:0]  rxShiftReg;

  // frame register shifts toward bit 0, filling with idle ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFrame <= '1;
    end else if (strobes.txLoad) begin
      txFrame <= {1'b1, txByte, 1'b0};
    end else if (strobes.txShift) begin
      txFrame <= {1'b1, txFrame[FRAME_BITS-1:1]};
    end
  end

  assign txLine = txFrame[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftReg <= '0;
      rxByte     <= '0;
      rxFrameErr <= 1'b0;
    end else begin
      if (strobes.rxShift) begin
        rxShiftReg <= {rxLine, rxShiftReg[DATA_BITS-1:1]};
      end
      if (strobes.rxCapture) begin
        rxByte     <= rxShiftReg;
        rxFrameErr <= !rxLine;
      end
    end
  end

  AST_TX_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txLoad |-> txLine); // R4
endmodule

// File: rtl/bittime_xcvr.sv
module bittime_xcvr
  import bittime_xcvr_pkg::*;
#(
  parameter int BT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [BT_W-1:0] bitTime,
  input  logic            rxLine,
  input  logic            rxEnable,
  input  logic [7:0]      txByte,
  input  logic            txStart,
  output logic            txLine,
  output logic [7:0]      rxByte,
  output logic            rxFrameErr,
  output logic            rxDone,
  output logic            rxBusy,
  output logic            txDone,
  output logic            txBusy
);
  ctrlStrobes_t strobes;

  bittime_xcvr_ctrl #(.BT_W(BT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bitTime(bitTime), .rxLine(rxLine),
    .rxEnable(rxEnable), .txStart(txStart), .strobes(strobes),
    .txBusy(txBusy), .txDone(txDone), .rxBusy(rxBusy), .rxDone(rxDone)
  );

  bittime_xcvr_dp uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txByte(txByte),
    .rxLine(rxLine), .txLine(txLine), .rxByte(rxByte), .rxFrameErr(rxFrameErr)
  );

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine); // R2
  AST_TXDONE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> txDone); // R5
  AST_BITTIME_MIN: assert property (@(posedge clk) disable iff (!rstN)
    bitTime >= BT_W'(BT_MIN)); // R11
endmodule

// File: tb/bittime_xcvr_test.sv
module bittime_xcvr_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] bitTime = 8'd34;
  logic       rxLine = 1'b1;
  logic       rxEnable = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic       txStart = 1'b0;
  logic       txLine, rxFrameErr, rxDone, rxBusy, txDone, txBusy;
  logic [7:0] rxByte;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bittime_xcvr uut (
    .clk(clk), .rstN(rstN), .bitTime(bitTime), .rxLine(rxLine),
    .rxEnable(rxEnable), .txByte(txByte), .txStart(txStart),
    .txLine(txLine), .rxByte(rxByte), .rxFrameErr(rxFrameErr),
    .rxDone(rxDone), .rxBusy(rxBusy), .txDone(txDone), .txBusy(txBusy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic frameBit(input logic [7:0] b, input int idx, input logic stopVal);
    if (idx == 0) return 1'b0;
    if (idx <= 8) return b[idx-1];
    if (idx == 9) return stopVal;
    return 1'b1;
  endfunction

  function automatic int rxDoneAt(input int bt);
    return 1 + (bt >> 1) + 9 * bt;
  endfunction

  // R2 R3 R4 R5: send one byte, compare the line cycle by cycle
  task automatic sendTx(input logic [7:0] b, input int bt, input bit injectStart);
    int bad = 0;
    int busyBad = 0;
    @(negedge clk);
    bitTime = 8'(bt);
    txByte  = b;
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    for (int n = 1; n <= 10 * bt; n++) begin
      if (txLine !== frameBit(b, (n - 1) / bt, 1'b1)) bad++;
      if (txBusy !== 1'b1 || txDone !== 1'b0) busyBad++;
      if (injectStart && n == 3) begin txStart = 1'b1; txByte = ~b; end
      if (injectStart && n == 4) begin txStart = 1'b0; txByte = b; end
      @(negedge clk);
    end
    check(bad == 0, injectStart ? "R4 frame after busy strobe" : "R2/R3 tx waveform", bad, 0);
    check(busyBad == 0, "R5 busy during frame", busyBad, 0);
    check(txDone === 1'b1 && txBusy === 1'b0 && txLine === 1'b1, "R5 done at stop end",
          {txDone, txBusy, txLine}, 3'b101);
    @(negedge clk);
    check(txDone === 1'b0, "R5 done pulse width", txDone, 0);
  endtask

  // R6 R8 R9 R10: drive a frame and watch for the done pulse
  task automatic sendRx(input logic [7:0] b, input int bt, input logic stopVal, input bit enabled);
    int doneAt = -1;
    int doneCount = 0;
    int busySeen = 0;
    @(negedge clk);
    bitTime  = 8'(bt);
    rxEnable = enabled;
    for (int n = 0; n <= 11 * bt; n++) begin
      if (n > 0) begin
        if (rxDone === 1'b1) begin
          doneCount++;
          if (doneAt < 0) doneAt = n;
        end
        if (rxBusy === 1'b1) busySeen++;
      end
      rxLine = frameBit(b, n / bt, stopVal);
      if (doneAt == n && n > 0) begin
        check(rxByte === b, "R8 received byte", rxByte, b);
        check(rxFrameErr === !stopVal, "R9 framing flag", rxFrameErr, !stopVal);
      end
      @(negedge clk);
    end
    rxLine = 1'b1;
    if (enabled) begin
      check(doneAt == rxDoneAt(bt), "R6 stop sample timing", doneAt, rxDoneAt(bt));
      check(doneCount == 1, "R8 done pulse count", doneCount, 1);
    end else begin
      check(doneCount == 0 && busySeen == 0, "R10 disabled receiver idle", doneCount + busySeen, 0);
    end
    // let a low stop bit release before the next frame
    repeat (bt) @(negedge clk);
  endtask

  // R7: low glitch shorter than half a bit is rejected
  task automatic glitchRx(input int bt, input int lowCycles);
    int doneCount = 0;
    int busyAfter = 0;
    @(negedge clk);
    bitTime  = 8'(bt);
    rxEnable = 1'b1;
    rxLine   = 1'b0;
    for (int n = 1; n <= 2 * bt; n++) begin
      if (n == lowCycles) rxLine = 1'b1;
      @(negedge clk);
      if (rxDone === 1'b1) doneCount++;
      if (n > (bt >> 1) + 1 && rxBusy === 1'b1) busyAfter++;
    end
    check(doneCount == 0 && busyAfter == 0, "R7 false start abandoned", doneCount + busyAfter, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txLine === 1'b1 && txBusy === 1'b0 && txDone === 1'b0, "R1 tx reset",
          {txLine, txBusy, txDone}, 3'b100);
    check(rxBusy === 1'b0 && rxDone === 1'b0 && rxByte === 8'h00 && rxFrameErr === 1'b0,
          "R1 rx reset", {rxBusy, rxDone, rxFrameErr, rxByte}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    sendTx(8'hA5, 34, 1'b0);
    sendTx(8'h00, 16, 1'b0);          // R3 shortest legal bit
    sendTx(8'hFF, 30, 1'b0);          // R3 mis-programmed count shows directly
    sendTx(8'h3C, 20, 1'b1);          // R4 strobe while busy
    sendRx(8'h5A, 34, 1'b1, 1'b1);
    sendRx(8'hC3, 35, 1'b1, 1'b1);    // R6 odd count rounds down
    sendRx(8'h81, 16, 1'b1, 1'b1);
    sendRx(8'h7E, 24, 1'b0, 1'b1);    // R9 low stop bit
    sendRx(8'h11, 24, 1'b1, 1'b1);    // R9 flag clears
    sendRx(8'h99, 20, 1'b1, 1'b0);    // R10 disabled
    glitchRx(34, 5);                  // R7
    glitchRx(17, 3);                  // R7 odd count

    // constrained random mix
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      int bt;
      b  = 8'($urandom);
      bt = 16 + int'($urandom % 25);
      if (i % 2 == 0) sendTx(b, bt, ($urandom % 4) == 0);
      else sendRx(b, bt, ($urandom % 5) != 0, 1'b1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule